// File: doc/BRIEF.md
# Prescaled Interval Timer Channel

A single 16-bit timer channel. Each clock cycle it either steps its counter or holds it. Whether it steps depends on a hold control and on a power-of-two prescaler. The counter counts up or down. It wraps either over the full 16-bit range or at a programmed interval. Wrapping and landing on any of three compare values raise sticky status bits. A per-bit enable mask combines those bits into one level interrupt.

The surrounding logic owns the control fields, the interval value, the compare values and the enable mask, and drives them as steady levels. It pulses `cnt_rst` to restart the count and the prescaler phase. It pulses `sts_clr` when software consumes the status, which is the read-to-clear action. An external event-overflow pulse can set the top status bit, so that the status layout covers all six sources.

Top module: `ptmr_channel`

## Requirements
- R1: With `clk_ctrl[0]`=0 the count steps on every clock. With `clk_ctrl[0]`=1 and N=`clk_ctrl[4:1]`, it steps once every 2^(N+1) clocks. After `cnt_rst`, the first step comes 2^(N+1) clocks later (1 clock when the prescaler is off).
- R2: While `cnt_ctrl[0]`=1 the count and the prescaler phase hold, and no wrap or compare status is raised.
- R3: `cnt_ctrl[2]`=1 counts down and 0 counts up. With `cnt_ctrl[1]`=1 the count runs modulo `interval`+1; otherwise it runs modulo 0x10000. Counting up, the count returns to 0 after reaching the limit. Counting down from 0, it goes to the limit.
- R4: A wrap in either direction sets status bit 0 in interval mode and status bit 4 otherwise.
- R5: A `cnt_rst` pulse makes `count` read 0 on the next cycle, and it takes priority over a step.
- R6: With `cnt_ctrl[3]`=1, compare value i (bits 16i+15:16i of `match_val`) sets status bit i+1 on the step that lands the count on that value. A compare value above the current limit never fires. With `cnt_ctrl[3]`=0, no compare bit is set.
- R7: Status bits are sticky. `sts_clr` clears all six, but an event in the same cycle stays set.
- R8: `irq` is high exactly when the bitwise AND of `status` and `irq_en` is nonzero.
- R9: An `ext_evt` pulse sets status bit 5.
- R10: After `rst`, `count` is 0, `status` is 0 and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_ctrl | input | 5 | Bit 0 prescaler enable, bits 4:1 prescale exponent N |
| cnt_ctrl | input | 4 | Bit 0 hold, bit 1 interval mode, bit 2 count down, bit 3 compare enable |
| interval | input | 16 | Wrap limit used in interval mode |
| match_val | input | 48 | Three 16-bit compare values, compare 0 in the low bits |
| cnt_rst | input | 1 | Clears count and prescaler phase |
| sts_clr | input | 1 | Clears all status bits |
| ext_evt | input | 1 | External event-overflow pulse, sets status bit 5 |
| irq_en | input | 6 | Per-bit interrupt enable mask |
| count | output | 16 | Current count |
| status | output | 6 | Sticky status bits |
| irq | output | 1 | Level interrupt |

## Verification
A wrong prescaler phase or a wrong wrap limit shows on `count` within one step period of the first wrong step. From there the count drifts further from the expected value on every later step. A compare or wrap event raised on the wrong step shows in `status` and `irq` in the very cycle after that step. The bench checks every cycle, so it catches such an error immediately. A status bit that leaks without being cleared would show as a lost or extra bit after the next clear pulse.

// File: rtl/ptmr_pkg.sv
package ptmr_pkg;

    localparam int CNT_W     = 16;
    localparam int NUM_MATCH = 3;
    localparam int PSC_W     = 4;
    localparam int STS_W     = 6;

    localparam int ST_INTV = 0;
    localparam int ST_MAT0 = 1;
    localparam int ST_OVF  = 4;
    localparam int ST_EXT  = 5;

    typedef struct packed {
        logic match_en;
        logic down;
        logic intv_mode;
        logic hold;
    } cnt_ctrl_t;

    typedef struct packed {
        logic [PSC_W-1:0] exp_n;
        logic             enable;
    } clk_ctrl_t;

    function automatic logic [(2**PSC_W)-1:0] psc_mask(input logic [PSC_W-1:0] n);
        logic [(2**PSC_W)-1:0] ones;
        ones = '1;
        return ones >> ((2**PSC_W) - 1 - int'(n));
    endfunction

endpackage

// File: rtl/ptmr_prescaler.sv
module ptmr_prescaler
    import ptmr_pkg::*;
#(
    parameter int P_W = PSC_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           clr,
    input  logic           run,
    input  logic           psc_en,
    input  logic [P_W-1:0] psc_n,
    output logic           tick
);
    localparam int DIV_W = 2**P_W;

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] mask;

    always_comb begin
        mask = '1;
        mask = mask >> (DIV_W - 1 - int'(psc_n));
        tick = run && (!psc_en || ((div_q & mask) == mask));
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            div_q <= '0;
        end else if (run) begin
            div_q <= div_q + 1'b1;
        end
    end

    // R1: a fresh phase never ticks on the first prescaled cycle
    a_r1_no_tick_after_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> !(tick && psc_en));

    // R2: a held phase does not advance
    a_r2_phase_held: assert property (@(posedge clk) disable iff (rst)
        (!run && !clr) |=> $stable(div_q));

endmodule

// File: rtl/ptmr_counter.sv
module ptmr_counter
    import ptmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_rst,
    input  logic         tick,
    input  logic         down,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic [W-1:0] next_count,
    output logic         step,
    output logic         wrap_ev
);
    logic at_top;
    logic at_zero;
    logic wrap_c;

    always_comb begin
        at_top  = (count >= limit);
        at_zero = (count == '0);
        if (down) begin
            next_count = at_zero ? limit : count - 1'b1;
            wrap_c     = at_zero;
        end else begin
            next_count = at_top ? '0 : count + 1'b1;
            wrap_c     = at_top;
        end
        step    = tick && !cnt_rst;
        wrap_ev = step && wrap_c;
    end

    always_ff @(posedge clk) begin
        if (rst || cnt_rst) begin
            count <= '0;
        end else if (tick) begin
            count <= next_count;
        end
    end

    // R5: reset strobe forces zero next cycle
    a_r5_clear_to_zero: assert property (@(posedge clk) disable iff (rst)
        cnt_rst |=> (count == '0));

    // R2: no step means the count holds
    a_r2_hold_freezes: assert property (@(posedge clk) disable iff (rst)
        (!tick && !cnt_rst) |=> $stable(count));

    // R3: an up step from below the limit advances by one
    a_r3_up_by_one: assert property (@(posedge clk) disable iff (rst)
        (step && !down && (count < limit)) |=> (count == $past(count) + 1'b1));

endmodule

// File: rtl/ptmr_match.sv
module ptmr_match
    import ptmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         step,
    input  logic         enable,
    input  logic [W-1:0] next_count,
    input  logic [W-1:0] limit,
    input  logic [W-1:0] mval,
    output logic         hit
);
    always_comb begin
        hit = step && enable && (mval <= limit) && (next_count == mval);
    end

    // R6: a compare value beyond the limit stays silent
    always_comb begin
        a_r6_above_limit_silent: assert (!(hit && (mval > limit)));
    end

endmodule

// File: rtl/ptmr_status.sv
module ptmr_status
    import ptmr_pkg::*;
#(
    parameter int N = STS_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic [N-1:0] ev,
    output logic [N-1:0] sts
);
    always_ff @(posedge clk) begin
        if (rst) begin
            sts <= '0;
        end else begin
            sts <= (clr ? '0 : sts) | ev;
        end
    end

    // R7: without a clear no bit falls
    a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((sts & $past(sts)) == $past(sts)));

    // R7: a clear with no concurrent event empties the register
    a_r7_clear_empty: assert property (@(posedge clk) disable iff (rst)
        (clr && (ev == '0)) |=> (sts == '0));

    // R7: a concurrent event survives the clear
    a_r7_event_wins: assert property (@(posedge clk) disable iff (rst)
        (ev != '0) |=> ((sts & $past(ev)) == $past(ev)));

endmodule

// File: rtl/ptmr_channel.sv
module ptmr_channel
    import ptmr_pkg::*;
#(
    parameter int W  = CNT_W,
    parameter int NM = NUM_MATCH,
    parameter int PW = PSC_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PW:0]     clk_ctrl,
    input  logic [3:0]      cnt_ctrl,
    input  logic [W-1:0]    interval,
    input  logic [NM*W-1:0] match_val,
    input  logic            cnt_rst,
    input  logic            sts_clr,
    input  logic            ext_evt,
    input  logic [NM+2:0]   irq_en,
    output logic [W-1:0]    count,
    output logic [NM+2:0]   status,
    output logic            irq
);
    localparam int SW  = NM + 3;
    localparam int OVF = NM + 1;
    localparam int EXT = NM + 2;

    cnt_ctrl_t       cc;
    logic [W-1:0]    limit;
    logic            tick;
    logic            step;
    logic            wrap_ev;
    logic [W-1:0]    next_count;
    logic [NM-1:0]   hits;
    logic [SW-1:0]   events;

    always_comb begin
        cc    = cnt_ctrl_t'(cnt_ctrl);
        limit = cc.intv_mode ? interval : {W{1'b1}};
    end

    ptmr_prescaler #(.P_W(PW)) u_psc (
        .clk    (clk),
        .rst    (rst),
        .clr    (cnt_rst),
        .run    (!cc.hold),
        .psc_en (clk_ctrl[0]),
        .psc_n  (clk_ctrl[PW:1]),
        .tick   (tick)
    );

    ptmr_counter #(.W(W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .cnt_rst    (cnt_rst),
        .tick       (tick),
        .down       (cc.down),
        .limit      (limit),
        .count      (count),
        .next_count (next_count),
        .step       (step),
        .wrap_ev    (wrap_ev)
    );

    for (genvar i = 0; i < NM; i++) begin : g_match
        ptmr_match #(.W(W)) u_m (
            .step       (step),
            .enable     (cc.match_en),
            .next_count (next_count),
            .limit      (limit),
            .mval       (match_val[i*W +: W]),
            .hit        (hits[i])
        );
    end

    always_comb begin
        events              = '0;
        events[ST_INTV]     = wrap_ev && cc.intv_mode;
        events[NM:1]        = hits;
        events[OVF]         = wrap_ev && !cc.intv_mode;
        events[EXT]         = ext_evt;
    end

    ptmr_status #(.N(SW)) u_sts (
        .clk (clk),
        .rst (rst),
        .clr (sts_clr),
        .ev  (events),
        .sts (status)
    );

    always_comb begin
        irq = |(status & irq_en);
    end

    // R8: a zero mask keeps the line low
    a_r8_masked_quiet: assert property (@(posedge clk) disable iff (rst)
        (irq_en == '0) |-> !irq);

    // R4: the overflow bit rises only from free-running wraps or never in interval mode
    a_r4_ovf_not_interval: assert property (@(posedge clk) disable iff (rst)
        $rose(status[OVF]) |-> !$past(cnt_ctrl[1]));

    // R10: held in reset the status is empty on the next cycle
    a_r10_reset_empty: assert property (@(posedge clk)
        rst |=> (status == '0 && count == '0));

endmodule

// File: tb/ptmr_channel_tb.sv
module ptmr_channel_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [4:0]  clk_ctrl = '0;
    logic [3:0]  cnt_ctrl = 4'b0001;
    logic [15:0] interval = '0;
    logic [47:0] match_val = '0;
    logic        cnt_rst = 1'b0;
    logic        sts_clr = 1'b0;
    logic        ext_evt = 1'b0;
    logic [5:0]  irq_en = '0;
    logic [15:0] count;
    logic [5:0]  status;
    logic        irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    ptmr_channel dut_i (
        .clk(clk), .rst(rst), .clk_ctrl(clk_ctrl), .cnt_ctrl(cnt_ctrl),
        .interval(interval), .match_val(match_val), .cnt_rst(cnt_rst),
        .sts_clr(sts_clr), .ext_evt(ext_evt), .irq_en(irq_en),
        .count(count), .status(status), .irq(irq)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic bit fires(int m, int t, int lim, bit down);
        if (m > lim) return 1'b0;
        if (m == 0) return t >= lim + 1;
        if (!down) return t >= m;
        return t >= lim + 1 - m;
    endfunction

    function automatic int exp_count(int t, int lim, bit down);
        int r;
        r = t % (lim + 1);
        if (down) r = (lim + 1 - r) % (lim + 1);
        return r;
    endfunction

    task automatic run_case(bit pe, int n, bit down, bit intv, int lim, bit me);
        int p, k, m0, m1, m2, t;
        logic [5:0] es;
        p  = pe ? (1 << (n + 1)) : 1;
        m0 = 0;
        m1 = 2;
        m2 = intv ? lim + 1 : 16'hFFFE;
        clk_ctrl  = {n[3:0], pe};
        cnt_ctrl  = {me, down, intv, 1'b0};
        interval  = lim[15:0];
        match_val = {m2[15:0], m1[15:0], m0[15:0]};
        irq_en    = 6'h3F;
        cnt_rst   = 1'b1;
        sts_clr   = 1'b1;
        step();
        cnt_rst   = 1'b0;
        sts_clr   = 1'b0;
        check("R5 count after reset strobe", count, 0);
        k = intv ? p * (lim + 2) + 2 : p * 3 + 2;
        for (int j = 1; j <= k; j++) begin
            step();
            t = j / p;
            es = '0;
            if (t >= (down ? 1 : lim + 1)) es[intv ? 0 : 4] = 1'b1;
            if (me) begin
                es[1] = fires(m0, t, lim, down);
                es[2] = fires(m1, t, lim, down);
                es[3] = fires(m2, t, lim, down);
            end
            check("R1 R3 count", count, exp_count(t, lim, down));
            check("R4 R6 status", status, es);
            check("R8 irq", irq, (es != 0));
        end
    endtask

    initial begin
        logic [15:0] held_c;
        logic [5:0]  held_s;
        repeat (3) step();
        check("R10 count at reset", count, 0);
        check("R10 status at reset", status, 0);
        check("R10 irq at reset", irq, 0);
        rst = 1'b0;
        step();

        for (int ps = 0; ps < 4; ps++) begin
            for (int d = 0; d < 2; d++) begin
                run_case(ps != 0, (ps == 0) ? 0 : ps - 1, d[0], 1'b1, 4, 1'b1);
                run_case(ps != 0, (ps == 0) ? 0 : ps - 1, d[0], 1'b1, 6, 1'b1);
                run_case(ps != 0, (ps == 0) ? 0 : ps - 1, d[0], 1'b0, 16'hFFFF, 1'b1);
            end
        end
        // R6 compare disabled
        run_case(1'b0, 0, 1'b0, 1'b1, 5, 1'b0);

        // R2 hold: freeze count and status
        run_case(1'b0, 0, 1'b0, 1'b1, 9, 1'b1);
        held_c = count;
        held_s = status;
        cnt_ctrl[0] = 1'b1;
        for (int j = 0; j < 12; j++) begin
            step();
            check("R2 held count", count, held_c);
            check("R2 held status", status, held_s);
        end
        cnt_ctrl[0] = 1'b0;
        step();
        check("R2 resumes", count, (held_c + 1) % 10);

        // R7 clear versus concurrent wrap
        clk_ctrl = '0;
        cnt_ctrl = 4'b0010;
        interval = 16'd3;
        cnt_rst = 1'b1;
        sts_clr = 1'b1;
        step();
        cnt_rst = 1'b0;
        sts_clr = 1'b0;
        step(); step(); step();
        check("R7 no event yet", status, 0);
        sts_clr = 1'b1;
        step();
        sts_clr = 1'b0;
        check("R7 event wins over clear", status, 6'b000001);
        check("R4 interval wrap count", count, 0);
        step();
        check("R7 sticky", status, 6'b000001);
        sts_clr = 1'b1;
        step();
        sts_clr = 1'b0;
        check("R7 clear empties", status, 0);

        // R9 external event and R8 masking
        irq_en = 6'b000000;
        ext_evt = 1'b1;
        step();
        ext_evt = 1'b0;
        check("R9 ext bit", status, 6'b100000);
        check("R8 masked irq", irq, 0);
        irq_en = 6'b011111;
        #1;
        check("R8 other bits masked", irq, 0);
        irq_en = 6'b100000;
        #1;
        check("R8 enabled bit", irq, 1);

        // R3 R4 long free-running up wrap
        clk_ctrl = '0;
        cnt_ctrl = 4'b0000;
        cnt_rst = 1'b1;
        sts_clr = 1'b1;
        step();
        cnt_rst = 1'b0;
        sts_clr = 1'b0;
        repeat (65535) @(posedge clk);
        @(negedge clk);
        check("R3 top of range", count, 16'hFFFF);
        check("R4 no overflow yet", status, 0);
        step();
        check("R3 wrap to zero", count, 0);
        check("R4 overflow bit", status, 6'b010000);

        // R1 top prescale exponent: first step after 2^16 clocks
        clk_ctrl = {4'd15, 1'b1};
        cnt_ctrl = 4'b0000;
        cnt_rst = 1'b1;
        step();
        cnt_rst = 1'b0;
        repeat (65535) @(posedge clk);
        @(negedge clk);
        check("R1 no step before period", count, 0);
        step();
        check("R1 step at period", count, 1);

        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule